// File: doc/BRIEF.md
# Preloaded Up-Counting Timer with Update Events

This block is an up-counting timer with one compare channel. The counter runs from zero up to an active period value, then wraps. The compare output stays high while the count is below an active compare value. The period and compare values each have two copies: a preload register that software writes, and an active (shadow) register that the counter and the comparator use. With a channel's preload enable set, software writes only the preload copy. The new value moves into the active copy at the next update event. An update event is either a counter overflow or a software-requested update.

A software update copies both preload values into their active registers in the same cycle and clears the counter. An update-source bit stops a software update from raising the update flag, so software can set up a timer without taking a spurious interrupt. The counter can be started by software, or by a trigger input driven from another timer, which sets the run bit. The request bit clears itself after one cycle. A preload write in the cycle right after the update still cannot disturb the value that was just transferred.

Top module: `pwm_update_timer`

## Requirements
- R1: After reset, the run bit, both preload enables, the update-source bit and the update flag are 0. The period preload and active values are all ones. The compare preload and active values are 0. `cnt_o`, `pwm_o` and `irq_o` are 0.
- R2: With the period preload enable (control bit 1) set, a write to the period register (address 3) changes only the period preload copy. The active period (read at address 5) keeps its value until an update event.
- R3: With the compare preload enable (control bit 2) set, a write to the compare register (address 4) changes only the compare preload copy. The active compare (read at address 6) keeps its value until an update event.
- R4: Writing 1 to bit 0 of address 1 raises a one-cycle software update in the following cycle. This update copies both preload values into their active registers in that one cycle and sets the counter to 0.
- R5: A preload write made in the cycle in which the software update takes effect (the cycle after the request write) goes to the preload copy only. The active copy holds the value from before that write until the next update event.
- R6: When the update-source bit (control bit 3) is 1, a software update does not set the update flag. When it is 0, a software update sets the flag. A counter overflow always sets the flag.
- R7: The update flag (bit 0 of address 2) is cleared by writing 0 to that bit. Writing 1 to it leaves it unchanged. `irq_o` always equals the flag.
- R8: While the run bit is set, the counter increments once per cycle. In a cycle where the count is at or above the active period, the next count is 0 and an overflow update event occurs. The cycle length is therefore period+1.
- R9: `pwm_o` is registered. In each cycle it equals the result, in the previous cycle, of comparing the count with the active compare value (1 when the count was lower).
- R10: With a channel's preload enable clear, a write to that channel updates both its preload and active copies at once.
- R11: A high `trig_in` in any cycle sets the run bit (control bit 0) at the next edge. While the run bit is clear and no update occurs, the counter holds its value.
- R12: Register map for reads and writes: 0 control {bit3 update-source, bit2 compare preload enable, bit1 period preload enable, bit0 run}, 1 update request, 2 status flag, 3 period preload, 4 compare preload. Read-only: 5 active period, 6 active compare, 7 counter. Read data is registered and appears one cycle after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| trig_in | input | 1 | Start trigger from another timer |
| cnt_o | output | CNT_W | Current counter value |
| pwm_o | output | 1 | Compare output |
| irq_o | output | 1 | Update interrupt (flag level) |

## Verification
The bench builds the timer with an 8-bit counter (`CNT_W` = 8). At that width the reset period is 255, and every period value from 0 to 12 can be swept. Each period is paired with every compare value from 0 up to period+1, which covers the compare-always-low case (compare 0) and the compare-always-high case (compare above the period). For each pairing the bench follows the counter through three full wraps and computes the expected count and compare output arithmetically. Directed sequences cover the back-to-back request-then-write ordering, the update-source gating, flag clearing and the trigger start.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_UPD  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_PER  = 3'd3;
  localparam logic [AW-1:0] A_CMP  = 3'd4;
  localparam logic [AW-1:0] A_PERA = 3'd5;
  localparam logic [AW-1:0] A_CMPA = 3'd6;
  localparam logic [AW-1:0] A_CNT  = 3'd7;

  // bit 3 down to bit 0
  typedef struct packed {
    logic urs;
    logic cmp_pe;
    logic per_pe;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_low,
  input  logic              trig_i,
  input  logic              ovf_i,
  output ctrl_t             ctrl_o,
  output logic              ug_o,
  output logic              flag_o
);
  ctrl_t ctrl_q;
  logic  ug_q, flag_q;
  logic  ctrl_wr, ug_wr, st_clr, flag_set;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign ug_wr    = wr_en && (wr_addr == A_UPD) && wr_low[0];
  assign st_clr   = wr_en && (wr_addr == A_STAT) && !wr_low[0];
  assign flag_set = ovf_i || (ug_q && !ctrl_q.urs);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ug_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_low);
      if (trig_i)  ctrl_q.run <= 1'b1;
      ug_q <= ug_wr;
      if (flag_set)    flag_q <= 1'b1;
      else if (st_clr) flag_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign ug_o   = ug_q;
  assign flag_o = flag_q;

  // R4: request is a single-cycle pulse unless re-requested
  a_r4_ug_pulse: assert property (@(posedge clk) disable iff (rst)
    ug_q && !ug_wr |=> !ug_q);
  // R6: overflow always raises the flag
  a_r6_ovf_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> flag_q);
  // R6: gated software update leaves a clear flag clear
  a_r6_urs_quiet: assert property (@(posedge clk) disable iff (rst)
    ug_q && ctrl_q.urs && !ovf_i && !flag_q |=> !flag_q);
  // R11: trigger sets the run bit
  a_r11_trig_runs: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> ctrl_q.run);
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pe_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         uev_i,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pre_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      if (wr_i) pre_q <= wdata_i;
      if (wr_i && !pe_i) act_q <= wdata_i;
      else if (uev_i)    act_q <= pre_q;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;

  // R4/R5: transfer takes the preload value held before the event edge
  a_r5_transfer_old: assert property (@(posedge clk) disable iff (rst)
    uev_i && pe_i |=> act_q == $past(pre_q));
  // R2/R3: active copy is frozen between events and direct writes
  a_r2_active_hold: assert property (@(posedge clk) disable iff (rst)
    !uev_i && !(wr_i && !pe_i) |=> $stable(act_q));
  // R10: direct write lands in the active copy
  a_r10_direct: assert property (@(posedge clk) disable iff (rst)
    wr_i && !pe_i |=> act_q == $past(wdata_i));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         ug_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] compare_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q;
  logic         pwm_q, at_top;

  assign at_top = (cnt_q >= period_i);
  assign ovf_o  = run_i && !ug_i && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (ug_i)        cnt_q <= '0;
      else if (run_i)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      pwm_q <= (cnt_q < compare_i);
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;

  // R4: software update clears the counter
  a_r4_ug_zero: assert property (@(posedge clk) disable iff (rst)
    ug_i |=> cnt_q == '0);
  // R8: overflow wraps to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> cnt_q == '0);
  // R8: plain increment below the period
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    run_i && !ug_i && (cnt_q < period_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R11: idle counter holds
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !run_i && !ug_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_update_timer.sv
module pwm_update_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             irq_o
);
  localparam int NCH = 2;   // 0: period, 1: compare

  ctrl_t ctrl;
  logic  ug, flag, ovf, uev;
  logic [NCH-1:0]            pe, wr;
  logic [NCH-1:0][CNT_W-1:0] pre, act;
  logic [CNT_W-1:0]          cnt, rd_q;

  tmr_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_low (wr_data[CTRL_W-1:0]),
    .trig_i (trig_in),
    .ovf_i  (ovf),
    .ctrl_o (ctrl),
    .ug_o   (ug),
    .flag_o (flag)
  );

  assign uev   = ovf || ug;
  assign pe[0] = ctrl.per_pe;
  assign pe[1] = ctrl.cmp_pe;
  assign wr[0] = wr_en && (wr_addr == A_PER);
  assign wr[1] = wr_en && (wr_addr == A_CMP);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_shadow #(
      .W      (CNT_W),
      .RST_VAL((i == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
    ) u_sh (
      .clk    (clk),
      .rst    (rst),
      .pe_i   (pe[i]),
      .wr_i   (wr[i]),
      .wdata_i(wr_data),
      .uev_i  (uev),
      .pre_o  (pre[i]),
      .act_o  (act[i])
    );
  end

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run_i    (ctrl.run),
    .ug_i     (ug),
    .period_i (act[0]),
    .compare_i(act[1]),
    .cnt_o    (cnt),
    .ovf_o    (ovf),
    .pwm_o    (pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_q <= {{(CNT_W-CTRL_W){1'b0}}, ctrl};
        A_UPD:   rd_q <= {{(CNT_W-1){1'b0}}, ug};
        A_STAT:  rd_q <= {{(CNT_W-1){1'b0}}, flag};
        A_PER:   rd_q <= pre[0];
        A_CMP:   rd_q <= pre[1];
        A_PERA:  rd_q <= act[0];
        A_CMPA:  rd_q <= act[1];
        default: rd_q <= cnt;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign cnt_o   = cnt;
  assign irq_o   = flag;

  // R7: interrupt follows the flag after a clearing write
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_addr == A_STAT) && !wr_data[0] && !uev |=> !irq_o);
endmodule

// File: tb/sim_pwm_update_timer.sv
`timescale 1ns/1ps
module sim_pwm_update_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         trig_in = 1'b0;
  logic [W-1:0] cnt_o;
  logic         pwm_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_update_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in),
    .cnt_o(cnt_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  // two writes in consecutive cycles
  task automatic wr2(input logic [2:0] a1, input int d1, input logic [2:0] a2, input int d2);
    @(negedge clk); wr_en = 1'b1; wr_addr = a1; wr_data = W'(d1);
    @(negedge clk); wr_addr = a2; wr_data = W'(d2);
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input int exp);
    int v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 pwm", int'(pwm_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rchk("R1 ctrl", 3'd0, 0);
    rchk("R1 flag", 3'd2, 0);
    rchk("R1 per pre", 3'd3, 255);
    rchk("R1 cmp pre", 3'd4, 0);
    rchk("R1 per act", 3'd5, 255);
    rchk("R1 cmp act", 3'd6, 0);

    // R10 direct writes
    wr(3'd3, 20);
    rchk("R10 per act", 3'd5, 20);
    rchk("R10 per pre", 3'd3, 20);
    wr(3'd4, 5);
    rchk("R10 cmp act", 3'd6, 5);

    // R2 / R3 preloaded writes (R12 map)
    wr(3'd0, 6);
    rchk("R12 ctrl", 3'd0, 6);
    wr(3'd3, 33);
    rchk("R2 pre", 3'd3, 33);
    rchk("R2 act held", 3'd5, 20);
    wr(3'd4, 9);
    rchk("R3 pre", 3'd4, 9);
    rchk("R3 act held", 3'd6, 5);

    // R4 software update loads both, R5 back-to-back preload write
    wr(3'd2, 0);
    wr2(3'd1, 1, 3'd3, 40);
    rchk("R4 per act", 3'd5, 33);
    rchk("R4 cmp act", 3'd6, 9);
    rchk("R5 new pre", 3'd3, 40);
    rchk("R5 act kept", 3'd5, 33);
    rchk("R4 self clear", 3'd1, 0);
    chk("R4 cnt zero", int'(cnt_o), 0);
    rchk("R6 ug sets flag", 3'd2, 1);
    chk("R7 irq follows", int'(irq_o), 1);
    wr(3'd1, 1);
    rchk("R5 next update", 3'd5, 40);

    // R7 flag clear semantics
    wr(3'd2, 1);
    rchk("R7 write1 no effect", 3'd2, 1);
    wr(3'd2, 0);
    rchk("R7 write0 clears", 3'd2, 0);
    chk("R7 irq low", int'(irq_o), 0);

    // R6 update-source gating
    wr(3'd0, 14);
    wr(3'd1, 1);
    rchk("R6 urs quiet", 3'd2, 0);
    chk("R6 irq quiet", int'(irq_o), 0);
    wr(3'd3, 3);
    wr(3'd1, 1);
    wr(3'd0, 15);
    repeat (10) @(negedge clk);
    rchk("R6 ovf sets flag", 3'd2, 1);
    wr(3'd0, 6);
    wr(3'd2, 0);

    // R11 trigger start
    wr(3'd1, 1);
    repeat (5) @(negedge clk);
    chk("R11 idle hold", int'(cnt_o), 0);
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    chk("R11 first step", int'(cnt_o), 0);
    @(negedge clk);
    chk("R11 counting", int'(cnt_o), 1);
    rchk("R11 run bit", 3'd0, 7);
    wr(3'd0, 6);

    // R8 / R9 sweep
    for (int p = 0; p <= 12; p++) begin
      for (int c = 0; c <= p + 1; c++) begin
        int prev, expc;
        wr(3'd3, p);
        wr(3'd4, c);
        wr(3'd1, 1);
        wr(3'd0, 7);
        prev = 0;
        expc = (0 >= p) ? 0 : 1;
        for (int k = 0; k < 3 * (p + 1); k++) begin
          chk("R8 count", int'(cnt_o), expc);
          chk("R9 pwm", int'(pwm_o), (prev < c) ? 1 : 0);
          prev = expc;
          expc = (prev >= p) ? 0 : prev + 1;
          @(negedge clk);
        end
        wr(3'd0, 6);
      end
    end
    rchk("R8 overflow flag", 3'd2, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule